// File: doc/BRIEF.md
# Shared I/O Bus Requester Arbiter

This block decides, every clock cycle, which of thirteen requesters may use the internal I/O data bus that links peripherals to on-chip memory. Three of the requesters are not DMA channels: core accesses to the DMA configuration registers, loading of chained transfer descriptors, and direct reads and writes of internal memory from off-chip. The other ten are DMA channels, numbered 0 to 9. The outcome is a one-hot grant vector that is purely combinational from the inputs. A registered start strobe follows one cycle later and marks the cycle in which the granted transfer begins. Read and write transfers use the same request, grant and start sequence, so the arbiter has no notion of direction.

The overall order is fixed. A configuration input can switch the four lowest slots, channels 6 to 9, into round-robin order among themselves, and that group still always sits below every other requester. A per-channel enable mask keeps disabled channels from ever winning. A build parameter removes channels 4 and 5 for smaller chip variants. A second parameter can remove the round-robin hardware altogether.

Top module: `io_bus_arbiter`

## Requirements
- R1: Grant bits are indexed by slot, from highest to lowest priority: 0 core register access, 1–4 channels 0–3, 5 descriptor loading, 6 external direct access, 7–12 channels 4–9. Only the lowest-numbered eligible slot is granted in that cycle.
- R2: `grant_o` is one-hot when any eligible request exists. It is all zeros otherwise, including during and right after reset.
- R3: One clock after a cycle with a non-zero grant, `start_o` is high for exactly that one cycle and `start_idx_o` holds the granted slot number. After a cycle with no grant, `start_o` is low.
- R4: Channel n, where enable bit n of `chan_en_i` is 0, never receives a grant, even if its request is active.
- R5: Slots 0, 5 and 6 are not affected by `chan_en_i`.
- R6: While `rotate_en_i` is 1, the group of slots 9–12 is ordered round-robin. A grant to group member k (slot 9+k) makes member k+1 (mod 4) the group's highest-priority member on the next cycle.
- R7: After reset, the round-robin pointer selects member 0 (channel 6). In any mode, any eligible request in slots 0–8 beats every group member.
- R8: While `rotate_en_i` is 0, the group is ordered channel 6 > 7 > 8 > 9 and the round-robin pointer keeps its value.
- R9: With `HAS_MID_CHANS` = 0, slots 7 and 8 (channels 4 and 5) are never granted. They do not block lower slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 13 | Request per slot (slot numbering as in R1) |
| chan_en_i | input | 10 | Enable per DMA channel, bit n = channel n |
| rotate_en_i | input | 1 | 1 = round-robin order within channels 6–9 |
| grant_o | output | 13 | One-hot grant per slot |
| start_o | output | 1 | Transfer start strobe, one cycle after a grant |
| start_idx_o | output | 4 | Slot number of the transfer that starts |

## Verification
Two functions can meet in one cycle. In the first, a group grant moves the round-robin pointer while a higher slot is also requesting, so the group loses and the pointer must stay where it is. The bench provokes this by sweeping every one of the 8192 request patterns in both modes, under changing enable masks, so requests above the group and inside it overlap in every combination. In the second, the start strobe for the previous grant is checked in the same cycle as a new grant. Each is judged against a bench model that keeps its own copy of the pointer and the pending start.

// File: rtl/io_bus_arb_pkg.sv
package io_bus_arb_pkg;

   // Fixed slot positions of the non-DMA requesters.
   localparam int SLOT_CORE  = 0;
   localparam int SLOT_CHAIN = 5;
   localparam int SLOT_XDIR  = 6;

   // Maps a priority slot to its DMA channel, or -1 for a non-DMA slot.
   function automatic int slot_chan(input int slot);
      if (slot >= 1 && slot <= 4) return slot - 1;
      if (slot >= 7)              return slot - 3;
      return -1;
   endfunction

   // Inverse map: DMA channel to priority slot.
   function automatic int chan_slot(input int ch);
      return (ch < 4) ? ch + 1 : ch + 3;
   endfunction

endpackage

// File: rtl/arb_req_qual.sv
module arb_req_qual
   import io_bus_arb_pkg::*;
#(
   parameter int NUM_CH        = 10,
   parameter bit HAS_MID_CHANS = 1'b1,
   localparam int NUM_SLOTS    = NUM_CH + 3
) (
   input  logic [NUM_SLOTS-1:0] req_i,
   input  logic [NUM_CH-1:0]    chan_en_i,
   output logic [NUM_SLOTS-1:0] elig_o
);

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam int CH = slot_chan(s);
      if (CH < 0) begin : g_free
         assign elig_o[s] = req_i[s];
      end else if (!HAS_MID_CHANS && (CH == 4 || CH == 5)) begin : g_gone
         assign elig_o[s] = 1'b0;
      end else begin : g_dma
         assign elig_o[s] = req_i[s] & chan_en_i[CH];
      end
   end

endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
   parameter int W   = 9,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req_i,
   output logic [W-1:0]  gnt_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);

   always_comb begin
      gnt_o = '0;
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            gnt_o    = '0;
            gnt_o[i] = 1'b1;
            idx_o    = IW'(i);
         end
      end
   end

   assign any_o = |req_i;

endmodule

// File: rtl/arb_rot_pick.sv
module arb_rot_pick #(
   parameter int W   = 4,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  req_i,
   input  logic [IW-1:0] top_i,
   output logic [W-1:0]  gnt_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);

   logic [IW-1:0] m;

   always_comb begin
      gnt_o = '0;
      idx_o = '0;
      m     = '0;
      for (int k = W - 1; k >= 0; k--) begin
         m = top_i + IW'(k);
         if (req_i[m]) begin
            gnt_o    = '0;
            gnt_o[m] = 1'b1;
            idx_o    = m;
         end
      end
   end

   assign any_o = |req_i;

endmodule

// File: rtl/arb_start_reg.sv
module arb_start_reg #(
   parameter int W   = 13,
   localparam int IW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  gnt_i,
   output logic          start_o,
   output logic [IW-1:0] start_idx_o
);

   logic [IW-1:0] enc;

   always_comb begin
      enc = '0;
      for (int i = 0; i < W; i++) begin
         if (gnt_i[i]) enc = IW'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_o     <= 1'b0;
         start_idx_o <= '0;
      end else begin
         start_o     <= |gnt_i;
         start_idx_o <= enc;
      end
   end

endmodule

// File: rtl/io_bus_arbiter.sv
module io_bus_arbiter #(
   parameter int NUM_CH        = 10,
   parameter int GRP_N         = 4,
   parameter bit HAS_MID_CHANS = 1'b1,
   parameter bit ROT_SUPPORT   = 1'b1,
   localparam int NUM_SLOTS    = NUM_CH + 3,
   localparam int SLOT_W       = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] req_i,
   input  logic [NUM_CH-1:0]    chan_en_i,
   input  logic                 rotate_en_i,
   output logic [NUM_SLOTS-1:0] grant_o,
   output logic                 start_o,
   output logic [SLOT_W-1:0]    start_idx_o
);

   localparam int GRP_BASE = NUM_SLOTS - GRP_N;
   localparam int UP_W     = GRP_BASE;
   localparam int UP_IW    = $clog2(UP_W);
   localparam int PTR_W    = $clog2(GRP_N);

   if (NUM_CH != 10) begin : g_chk_ch
      $error("io_bus_arbiter: slot layout needs NUM_CH == 10");
   end
   if (GRP_N != 4) begin : g_chk_grp
      $error("io_bus_arbiter: round-robin group must hold channels 6..9");
   end
   if ((1 << PTR_W) != GRP_N) begin : g_chk_pow2
      $error("io_bus_arbiter: GRP_N must be a power of two");
   end

   logic [NUM_SLOTS-1:0] elig;
   logic [UP_W-1:0]      up_gnt;
   logic [UP_IW-1:0]     up_idx;
   logic                 up_any;
   logic [GRP_N-1:0]     grp_gnt;
   logic [PTR_W-1:0]     grp_idx;
   logic                 grp_any;

   arb_req_qual #(
      .NUM_CH        (NUM_CH),
      .HAS_MID_CHANS (HAS_MID_CHANS)
   ) u_qual (
      .req_i     (req_i),
      .chan_en_i (chan_en_i),
      .elig_o    (elig)
   );

   arb_fixed_pick #(.W(UP_W)) u_up_pick (
      .req_i (elig[UP_W-1:0]),
      .gnt_o (up_gnt),
      .idx_o (up_idx),
      .any_o (up_any)
   );

   if (ROT_SUPPORT) begin : g_rot
      logic [PTR_W-1:0] ptr_q;
      logic [PTR_W-1:0] top;

      assign top = rotate_en_i ? ptr_q : '0;

      arb_rot_pick #(.W(GRP_N)) u_grp_pick (
         .req_i (elig[NUM_SLOTS-1:GRP_BASE]),
         .top_i (top),
         .gnt_o (grp_gnt),
         .idx_o (grp_idx),
         .any_o (grp_any)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ptr_q <= '0;
         end else if (rotate_en_i && !up_any && grp_any) begin
            ptr_q <= grp_idx + PTR_W'(1);
         end
      end
   end else begin : g_fix
      arb_fixed_pick #(.W(GRP_N)) u_grp_pick (
         .req_i (elig[NUM_SLOTS-1:GRP_BASE]),
         .gnt_o (grp_gnt),
         .idx_o (grp_idx),
         .any_o (grp_any)
      );
   end

   assign grant_o = up_any ? {{GRP_N{1'b0}}, up_gnt}
                           : {grp_gnt, {UP_W{1'b0}}};

   arb_start_reg #(.W(NUM_SLOTS)) u_start (
      .clk         (clk),
      .rst_n       (rst_n),
      .gnt_i       (grant_o),
      .start_o     (start_o),
      .start_idx_o (start_idx_o)
   );

endmodule

// File: rtl/io_bus_arbiter_chk.sv
module io_bus_arbiter_chk
   import io_bus_arb_pkg::*;
#(
   parameter int NUM_CH        = 10,
   parameter int GRP_N         = 4,
   parameter bit HAS_MID_CHANS = 1'b1,
   localparam int NUM_SLOTS    = NUM_CH + 3,
   localparam int SLOT_W       = $clog2(NUM_SLOTS),
   localparam int GRP_BASE     = NUM_SLOTS - GRP_N
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_SLOTS-1:0] req_i,
   input logic [NUM_CH-1:0]    chan_en_i,
   input logic [NUM_SLOTS-1:0] grant_o,
   input logic                 start_o,
   input logic [SLOT_W-1:0]    start_idx_o
);

   logic [NUM_SLOTS-1:0] gnt_q;
   logic                 seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         gnt_q  <= grant_o;
         seen_q <= 1'b1;
      end
   end

   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & ~req_i) == '0);

   a_r3_start_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> (start_o == (|gnt_q)));

   a_r3_start_index: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && start_o) |-> gnt_q[start_idx_o]);

   a_r5_core_wins: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[SLOT_CORE] |-> grant_o[SLOT_CORE]);

   a_r7_group_below: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[SLOT_CORE] || req_i[SLOT_CHAIN] || req_i[SLOT_XDIR])
         |-> (grant_o[NUM_SLOTS-1:GRP_BASE] == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      a_r4_disabled_blocked: assert property (@(posedge clk) disable iff (!rst_n)
         !chan_en_i[c] |-> !grant_o[chan_slot(c)]);
   end

   if (!HAS_MID_CHANS) begin : g_gone
      a_r9_removed_silent: assert property (@(posedge clk) disable iff (!rst_n)
         !grant_o[chan_slot(4)] && !grant_o[chan_slot(5)]);
   end

endmodule

bind io_bus_arbiter io_bus_arbiter_chk #(
   .NUM_CH        (NUM_CH),
   .GRP_N         (GRP_N),
   .HAS_MID_CHANS (HAS_MID_CHANS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .chan_en_i   (chan_en_i),
   .grant_o     (grant_o),
   .start_o     (start_o),
   .start_idx_o (start_idx_o)
);

// File: tb/io_bus_arbiter_bench.sv
`timescale 1ns/1ps
module io_bus_arbiter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] req_r = '0;
   logic [9:0]  en_r = '0;
   logic        rot_r = 1'b0;

   logic [12:0] gnt_a, gnt_b;
   logic        st_a, st_b;
   logic [3:0]  sidx_a, sidx_b;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   int ptr_a = 0, ptr_b = 0;
   int pend_a = -1, pend_b = -1;

   always #5 clk = ~clk;

   io_bus_arbiter u_io_bus_arbiter (
      .clk (clk), .rst_n (rst_n), .req_i (req_r), .chan_en_i (en_r),
      .rotate_en_i (rot_r), .grant_o (gnt_a), .start_o (st_a),
      .start_idx_o (sidx_a)
   );

   io_bus_arbiter #(.HAS_MID_CHANS(1'b0)) u_io_bus_arbiter_lite (
      .clk (clk), .rst_n (rst_n), .req_i (req_r), .chan_en_i (en_r),
      .rotate_en_i (rot_r), .grant_o (gnt_b), .start_o (st_b),
      .start_idx_o (sidx_b)
   );

   function automatic int model_pick(logic [12:0] r, logic [9:0] e,
                                     bit rot, int ptr, bit mid);
      logic [12:0] el;
      for (int s = 0; s < 13; s++) begin
         int ch;
         ch = (s >= 1 && s <= 4) ? s - 1 : (s >= 7 ? s - 3 : -1);
         if (ch < 0) el[s] = r[s];
         else el[s] = r[s] & e[ch] & (mid || (ch != 4 && ch != 5));
      end
      for (int s = 0; s < 9; s++) if (el[s]) return s;
      for (int k = 0; k < 4; k++) begin
         int m;
         m = rot ? (ptr + k) % 4 : k;
         if (el[9 + m]) return 9 + m;
      end
      return -1;
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_start(logic st, logic [3:0] idx, int pend, string who);
      if (pend < 0) check(st == 1'b0, {"R3 ", who}, st, 0);
      else check(st == 1'b1 && idx == pend[3:0], {"R3 ", who},
                 {st, idx}, {1'b1, pend[3:0]});
   endtask

   task automatic step(logic [12:0] r, logic [9:0] e, bit rot, string tag);
      int ga, gb;
      logic [12:0] ea, eb;
      check_start(st_a, sidx_a, pend_a, "full");
      check_start(st_b, sidx_b, pend_b, "lite");
      req_r = r; en_r = e; rot_r = rot;
      #1;
      ga = model_pick(r, e, rot, ptr_a, 1'b1);
      gb = model_pick(r, e, rot, ptr_b, 1'b0);
      ea = (ga < 0) ? '0 : (13'd1 << ga);
      eb = (gb < 0) ? '0 : (13'd1 << gb);
      check(gnt_a == ea, tag, gnt_a, ea);
      check(gnt_b == eb, (tag == "R6") ? "R6 lite" : "R9", gnt_b, eb);
      check($countones(gnt_a) <= 1, "R2", gnt_a, ea);
      if (rot && ga >= 9) ptr_a = (ga - 9 + 1) % 4;
      if (rot && gb >= 9) ptr_b = (gb - 9 + 1) % 4;
      pend_a = ga; pend_b = gb;
      @(negedge clk);
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(gnt_a == '0 && st_a == 1'b0, "R2 reset", {gnt_a, st_a}, 0);
      rst_n = 1'b1;

      // R7: right after reset, rotating group starts at channel 6.
      step(13'h1E00, 10'h3FF, 1'b1, "R7");
      // R6: rotation walks 7, 8, 9, 6, 7 with all four requesting.
      for (int i = 0; i < 5; i++) step(13'h1E00, 10'h3FF, 1'b1, "R6");
      // R7: descriptor loading beats the group regardless of pointer.
      step(13'h1E20, 10'h3FF, 1'b1, "R7");
      // R8: fixed mode ignores the moved pointer, channel 6 first.
      step(13'h1E00, 10'h3FF, 1'b0, "R8");
      step(13'h1C00, 10'h3FF, 1'b0, "R8");
      // R4: only channel 0 requests but it is disabled.
      step(13'h0002, 10'h3FE, 1'b0, "R4");
      // R5: non-DMA slots with every channel disabled.
      step(13'h0061, 10'h000, 1'b0, "R5");
      step(13'h0060, 10'h000, 1'b0, "R5");
      step(13'h0040, 10'h000, 1'b0, "R5");
      // R2: nothing requesting.
      step(13'h0000, 10'h3FF, 1'b0, "R2");

      // R1: every request pattern, fixed mode, all enabled.
      for (int i = 0; i < 8192; i++) step(13'(i), 10'h3FF, 1'b0, "R1");
      // R6/R4: every request pattern, rotating, varying enables.
      for (int i = 0; i < 8192; i++) begin
         logic [9:0] e;
         e = 10'((i * 677) ^ (i >> 4)) | 10'h2A5;
         if (i % 7 == 3) e[i % 10] = 1'b0;
         step(13'(i), e, 1'b1, "R6");
      end
      step(13'h0000, 10'h3FF, 1'b0, "R2");
      step(13'h0000, 10'h3FF, 1'b0, "R3");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule